// File: doc/BRIEF.md
# DMA Transfer Submission Register Block

This block is the software-facing front end of a single-channel DMA engine. Software programs the fields of a transfer into a set of staging registers: addresses, lengths, strides and a repeat flag. It then writes a start command. The block copies the staged fields into a small in-order queue of descriptors and tags each entry with a 5-bit transfer ID. Before submitting, software can read that ID back, so it can match completions to requests later.

Queued descriptors leave the block through a valid/ready handshake toward an address generator. Each handshake raises a start-of-transfer interrupt, which tells software that a queue slot has become free. The data mover reports each finished transfer by presenting its ID on a completion input. The block then sets that ID's bit in a done bitmap and raises an end-of-transfer interrupt. Both interrupt flags sit in a write-one-to-clear pending register. A mask register gates them onto a single interrupt line.

The registers use a flat 32-bit read/write port with a 12-bit byte address. Reads are combinational and have no side effects.

Top module: `dma_submit_csr`

## Requirements
- R1: After reset the mask register (0x080) reads 0x3, pending (0x084), next ID (0x404), done bitmap (0x428) and status (0x430) read 0, `irq` is low and `desc_valid` is low.
- R2: The staging registers read back what was written: flags at 0x40C (bit 0 only), destination address 0x410, source address 0x414, and four fields held as written in the low 24 bits with the upper bits reading 0. Those four fields are X length-minus-one at 0x418, Y length-minus-one at 0x41C, destination stride at 0x420 and source stride at 0x424. Each submitted descriptor carries these staged values.
- R3: A write to 0x408 with bit 0 set, while control bit 0 (enable, at 0x400) is 1 and the queue is not full, enqueues the staged descriptor. The descriptor takes the ID read from 0x404, and that ID then advances by one modulo 32. Submissions while the block is disabled are ignored.
- R4: Address 0x408 reads 1 while the queue holds DEPTH (default 4) descriptors, and 0 otherwise. A submission while the queue is full is ignored and does not advance the ID.
- R5: Descriptors leave in submission order. `desc_valid` is asserted only while the queue is non-empty, enable is 1 and control bit 1 (pause) is 0.
- R6: A descriptor whose flag bit 0 (cyclic) was set stays at the head of the queue. It is offered again, with the same ID, after every handshake.
- R7: Pending bit 0 is set by every descriptor handshake and pending bit 1 by every completion input. Writing ones to 0x084 clears those bits, and a set in the same cycle wins over a clear.
- R8: `irq` is high exactly when a pending bit is set whose mask bit is 0. Address 0x088 reads the pending bits with the masked ones forced to 0.
- R9: A completion with ID n sets bit n of 0x428. Bit n clears when ID n is assigned to a new submission, unless a completion for n arrives in the same cycle.
- R10: Writing control with bit 0 clear empties the queue but does not rewind the next ID. Status at 0x430 shows bit 0 = queue non-empty, bit 1 = queue full, and bits 8 and up = queue occupancy.
- R11: Address 0x42C reads the ID of the descriptor most recently handed out. Addresses 0x434 and 0x438 read its source and destination addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register byte address |
| csr_wen | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |
| desc_valid | output | 1 | Head descriptor offered to the address generator |
| desc_ready | input | 1 | Address generator takes the head descriptor |
| desc_id | output | 5 | Transfer ID of the head descriptor |
| desc_cyclic | output | 1 | Head descriptor repeats |
| desc_dst | output | 32 | Destination address |
| desc_src | output | 32 | Source address |
| desc_xlen | output | 24 | X length minus one |
| desc_ylen | output | 24 | Y length minus one |
| desc_dstride | output | 24 | Destination stride |
| desc_sstride | output | 24 | Source stride |
| cpl_valid | input | 1 | A transfer has completed |
| cpl_id | input | 5 | ID of the completed transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue and then submits once more. A design that accepted the extra write would lose a descriptor or skip an ID. The bench also runs the ID counter past 31 back to a reused ID and confirms that the stale done bit clears. A design without that clear would report a transfer finished before it ran. Two further cases are a pending clear that lands in the same cycle as a completion, where a wrong priority silently drops an end-of-transfer event, and a cyclic descriptor, which must be re-offered with its ID unchanged rather than retired. Pause must hold `desc_valid` low. An abort must empty the queue while keeping the ID sequence running, so that stale completions cannot alias new transfers.

// File: rtl/dmasub_pkg.sv
package dmasub_pkg;

    localparam int ID_W    = 5;
    localparam int NUM_IDS = 1 << ID_W;
    localparam int AW      = 32;
    localparam int LW      = 24;
    localparam int IRQ_W   = 2;

    localparam logic [11:0] OFS_IMASK   = 12'h080;
    localparam logic [11:0] OFS_IPEND   = 12'h084;
    localparam logic [11:0] OFS_ISRC    = 12'h088;
    localparam logic [11:0] OFS_CTRL    = 12'h400;
    localparam logic [11:0] OFS_NEXTID  = 12'h404;
    localparam logic [11:0] OFS_START   = 12'h408;
    localparam logic [11:0] OFS_FLAGS   = 12'h40C;
    localparam logic [11:0] OFS_DST     = 12'h410;
    localparam logic [11:0] OFS_SRC     = 12'h414;
    localparam logic [11:0] OFS_XLEN    = 12'h418;
    localparam logic [11:0] OFS_YLEN    = 12'h41C;
    localparam logic [11:0] OFS_DSTRIDE = 12'h420;
    localparam logic [11:0] OFS_SSTRIDE = 12'h424;
    localparam logic [11:0] OFS_DONE    = 12'h428;
    localparam logic [11:0] OFS_ACTID   = 12'h42C;
    localparam logic [11:0] OFS_STATUS  = 12'h430;
    localparam logic [11:0] OFS_CURSRC  = 12'h434;
    localparam logic [11:0] OFS_CURDST  = 12'h438;

    localparam int IRQ_SOT = 0;
    localparam int IRQ_EOT = 1;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            cyc;
        logic [AW-1:0]   dst;
        logic [AW-1:0]   src;
        logic [LW-1:0]   xlen;
        logic [LW-1:0]   ylen;
        logic [LW-1:0]   dstr;
        logic [LW-1:0]   sstr;
    } xfer_desc_t;

    typedef struct packed {
        logic pause;
        logic en;
    } ctrl_t;

    function automatic logic [31:0] len_word(input logic [LW-1:0] v);
        return 32'(v);
    endfunction

endpackage

// File: rtl/dmasub_queue.sv
module dmasub_queue
    import dmasub_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  xfer_desc_t       push_data,
    input  logic             advance,
    input  logic             flush,
    output xfer_desc_t       head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    xfer_desc_t       slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (advance) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, advance})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/dmasub_idtrack.sv
module dmasub_idtrack
    import dmasub_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc,
    input  logic               cpl_valid,
    input  logic [ID_W-1:0]    cpl_id,
    output logic [ID_W-1:0]    next_id,
    output logic [NUM_IDS-1:0] done_map
);

    logic [NUM_IDS-1:0] done_nxt;

    always_comb begin
        done_nxt = done_map;
        if (alloc) begin
            done_nxt[next_id] = 1'b0;
        end
        if (cpl_valid) begin
            done_nxt[cpl_id] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_id  <= '0;
            done_map <= '0;
        end else begin
            done_map <= done_nxt;
            if (alloc) begin
                next_id <= next_id + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmasub_irq.sv
module dmasub_irq
    import dmasub_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_sot,
    input  logic             ev_eot,
    input  logic             wr_pend,
    input  logic             wr_mask,
    input  logic [IRQ_W-1:0] wbits,
    output logic [IRQ_W-1:0] pend,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] active,
    output logic             irq
);

    logic [IRQ_W-1:0] pend_nxt;
    logic [IRQ_W-1:0] events;

    assign events = {ev_eot, ev_sot};

    always_comb begin
        pend_nxt = pend;
        if (wr_pend) begin
            pend_nxt = pend_nxt & ~wbits;
        end
        pend_nxt = pend_nxt | events;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= pend_nxt;
            if (wr_mask) begin
                mask <= wbits;
            end
        end
    end

    assign active = pend & ~mask;
    assign irq    = |active;

endmodule

// File: rtl/dma_submit_csr.sv
module dma_submit_csr
    import dmasub_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     csr_addr,
    input  logic            csr_wen,
    input  logic [31:0]     csr_wdata,
    output logic [31:0]     csr_rdata,
    output logic            desc_valid,
    input  logic            desc_ready,
    output logic [ID_W-1:0] desc_id,
    output logic            desc_cyclic,
    output logic [AW-1:0]   desc_dst,
    output logic [AW-1:0]   desc_src,
    output logic [LW-1:0]   desc_xlen,
    output logic [LW-1:0]   desc_ylen,
    output logic [LW-1:0]   desc_dstride,
    output logic [LW-1:0]   desc_sstride,
    input  logic            cpl_valid,
    input  logic [ID_W-1:0] cpl_id,
    output logic            irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    ctrl_t              ctrl;
    xfer_desc_t         stage;
    xfer_desc_t         head;
    logic [CNT_W-1:0]   q_count;
    logic               q_empty;
    logic               q_full;
    logic [ID_W-1:0]    next_id;
    logic [NUM_IDS-1:0] done_map;
    logic [IRQ_W-1:0]   pend;
    logic [IRQ_W-1:0]   mask;
    logic [IRQ_W-1:0]   irq_active;
    logic [ID_W-1:0]    act_id;
    logic [AW-1:0]      cur_src;
    logic [AW-1:0]      cur_dst;

    logic wr_ctrl, wr_start, wr_pend, wr_mask;
    logic push, handshake, advance, flush;

    assign wr_ctrl  = csr_wen && (csr_addr == OFS_CTRL);
    assign wr_start = csr_wen && (csr_addr == OFS_START) && csr_wdata[0];
    assign wr_pend  = csr_wen && (csr_addr == OFS_IPEND);
    assign wr_mask  = csr_wen && (csr_addr == OFS_IMASK);

    assign push      = wr_start && ctrl.en && !q_full;
    assign flush     = wr_ctrl && !csr_wdata[0];
    assign desc_valid = !q_empty && ctrl.en && !ctrl.pause;
    assign handshake = desc_valid && desc_ready;
    assign advance   = handshake && !head.cyc;

    // Staging and control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            stage <= '0;
        end else if (csr_wen) begin
            unique case (csr_addr)
                OFS_CTRL:    ctrl       <= ctrl_t'(csr_wdata[1:0]);
                OFS_FLAGS:   stage.cyc  <= csr_wdata[0];
                OFS_DST:     stage.dst  <= csr_wdata[AW-1:0];
                OFS_SRC:     stage.src  <= csr_wdata[AW-1:0];
                OFS_XLEN:    stage.xlen <= csr_wdata[LW-1:0];
                OFS_YLEN:    stage.ylen <= csr_wdata[LW-1:0];
                OFS_DSTRIDE: stage.dstr <= csr_wdata[LW-1:0];
                OFS_SSTRIDE: stage.sstr <= csr_wdata[LW-1:0];
                default:     ;
            endcase
        end
    end

    // Record of the descriptor most recently handed out
    always_ff @(posedge clk) begin
        if (rst) begin
            act_id  <= '0;
            cur_src <= '0;
            cur_dst <= '0;
        end else if (handshake) begin
            act_id  <= head.id;
            cur_src <= head.src;
            cur_dst <= head.dst;
        end
    end

    xfer_desc_t push_data;
    always_comb begin
        push_data    = stage;
        push_data.id = next_id;
    end

    dmasub_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .advance   (advance),
        .flush     (flush),
        .head      (head),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full)
    );

    dmasub_idtrack u_ids (
        .clk       (clk),
        .rst       (rst),
        .alloc     (push),
        .cpl_valid (cpl_valid),
        .cpl_id    (cpl_id),
        .next_id   (next_id),
        .done_map  (done_map)
    );

    dmasub_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .ev_sot  (handshake),
        .ev_eot  (cpl_valid),
        .wr_pend (wr_pend),
        .wr_mask (wr_mask),
        .wbits   (csr_wdata[IRQ_W-1:0]),
        .pend    (pend),
        .mask    (mask),
        .active  (irq_active),
        .irq     (irq)
    );

    assign desc_id      = head.id;
    assign desc_cyclic  = head.cyc;
    assign desc_dst     = head.dst;
    assign desc_src     = head.src;
    assign desc_xlen    = head.xlen;
    assign desc_ylen    = head.ylen;
    assign desc_dstride = head.dstr;
    assign desc_sstride = head.sstr;

    // Combinational read path
    always_comb begin
        unique case (csr_addr)
            OFS_IMASK:   csr_rdata = 32'(mask);
            OFS_IPEND:   csr_rdata = 32'(pend);
            OFS_ISRC:    csr_rdata = 32'(irq_active);
            OFS_CTRL:    csr_rdata = 32'(ctrl);
            OFS_NEXTID:  csr_rdata = 32'(next_id);
            OFS_START:   csr_rdata = 32'(q_full);
            OFS_FLAGS:   csr_rdata = 32'(stage.cyc);
            OFS_DST:     csr_rdata = 32'(stage.dst);
            OFS_SRC:     csr_rdata = 32'(stage.src);
            OFS_XLEN:    csr_rdata = len_word(stage.xlen);
            OFS_YLEN:    csr_rdata = len_word(stage.ylen);
            OFS_DSTRIDE: csr_rdata = len_word(stage.dstr);
            OFS_SSTRIDE: csr_rdata = len_word(stage.sstr);
            OFS_DONE:    csr_rdata = 32'(done_map);
            OFS_ACTID:   csr_rdata = 32'(act_id);
            OFS_STATUS:  csr_rdata = 32'({q_count, 6'b0, q_full, !q_empty});
            OFS_CURSRC:  csr_rdata = 32'(cur_src);
            OFS_CURDST:  csr_rdata = 32'(cur_dst);
            default:     csr_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/dma_submit_csr_chk.sv
module dma_submit_csr_chk
    import dmasub_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               desc_valid,
    input logic               desc_ready,
    input ctrl_t              ctrl,
    input logic [CNT_W-1:0]   q_count,
    input logic               push,
    input logic [ID_W-1:0]    next_id,
    input logic [NUM_IDS-1:0] done_map,
    input logic               cpl_valid,
    input logic [ID_W-1:0]    cpl_id,
    input logic [IRQ_W-1:0]   pend,
    input logic [IRQ_W-1:0]   mask,
    input logic               irq
);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(DEPTH));

    p_valid_gate_r5: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (ctrl.en && !ctrl.pause));

    p_id_step_r3: assert property (@(posedge clk) disable iff (rst)
        push |=> (next_id == $past(next_id) + 1'b1));

    p_sot_set_r7: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready) |=> pend[IRQ_SOT]);

    p_eot_set_r7: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> pend[IRQ_EOT]);

    p_done_set_r9: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> done_map[$past(cpl_id)]);

    p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (push && !(cpl_valid && cpl_id == next_id)) |=> !done_map[$past(next_id)]);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq);

endmodule

bind dma_submit_csr dma_submit_csr_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .ctrl       (ctrl),
    .q_count    (q_count),
    .push       (push),
    .next_id    (next_id),
    .done_map   (done_map),
    .cpl_valid  (cpl_valid),
    .cpl_id     (cpl_id),
    .pend       (pend),
    .mask       (mask),
    .irq        (irq)
);

// File: tb/tb_dma_submit_csr.sv
module tb_dma_submit_csr;
    import dmasub_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     csr_addr = '0;
    logic            csr_wen = 1'b0;
    logic [31:0]     csr_wdata = '0;
    logic [31:0]     csr_rdata;
    logic            desc_valid;
    logic            desc_ready = 1'b0;
    logic [ID_W-1:0] desc_id;
    logic            desc_cyclic;
    logic [AW-1:0]   desc_dst, desc_src;
    logic [LW-1:0]   desc_xlen, desc_ylen, desc_dstride, desc_sstride;
    logic            cpl_valid = 1'b0;
    logic [ID_W-1:0] cpl_id = '0;
    logic            irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_submit_csr #(.DEPTH(QDEPTH)) dut (.*);

    int n_checks = 0;
    int n_errs   = 0;

    // bench model
    logic [31:0] m_src[$];
    logic [31:0] m_dst[$];
    logic [31:0] m_xlen[$];
    int          m_id[$];
    logic [31:0] done_model = '0;
    int          next_model = 0;
    bit          en_model = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wen = 1'b1;
        @(negedge clk);
        csr_wen = 1'b0;
    endtask

    task automatic csr_read(input logic [11:0] a, output logic [31:0] r);
        @(negedge clk);
        csr_addr = a;
        #1 r = csr_rdata;
    endtask

    function automatic logic [31:0] fit_len(input logic [31:0] v);
        return v & 32'h00FF_FFFF;
    endfunction

    task automatic submit(input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] xl, input bit cyc);
        csr_write(OFS_SRC, s);
        csr_write(OFS_DST, d);
        csr_write(OFS_XLEN, xl);
        csr_write(OFS_FLAGS, 32'(cyc));
        csr_write(OFS_START, 32'h1);
        if (en_model && m_id.size() < QDEPTH) begin
            m_src.push_back(s);
            m_dst.push_back(d);
            m_xlen.push_back(fit_len(xl));
            m_id.push_back(next_model);
            done_model[next_model] = 1'b0;
            next_model = (next_model + 1) % 32;
        end
    endtask

    task automatic pop_check(input string req, input bit keep);
        @(negedge clk);
        desc_ready = 1'b1;
        #1;
        check(req, 32'(desc_valid), 32'h1);
        if (m_id.size() > 0) begin
            check(req, 32'(desc_id), 32'(m_id[0]));
            check(req, desc_src, m_src[0]);
            check(req, desc_dst, m_dst[0]);
            check(req, 32'(desc_xlen), m_xlen[0]);
        end
        @(negedge clk);
        desc_ready = 1'b0;
        if (!keep && m_id.size() > 0) begin
            void'(m_id.pop_front());
            void'(m_src.pop_front());
            void'(m_dst.pop_front());
            void'(m_xlen.pop_front());
        end
    endtask

    task automatic complete(input int id);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_id = 5'(id);
        @(negedge clk);
        cpl_valid = 1'b0;
        done_model[id] = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errs++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          cyc_id;
        int unsigned seed_val;
        seed_val = $urandom(32'd4711);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        csr_read(OFS_IMASK, r);  check("R1 mask", r, 32'h3);
        csr_read(OFS_IPEND, r);  check("R1 pend", r, 32'h0);
        csr_read(OFS_NEXTID, r); check("R1 nextid", r, 32'h0);
        csr_read(OFS_DONE, r);   check("R1 done", r, 32'h0);
        csr_read(OFS_STATUS, r); check("R1 status", r, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 valid", 32'(desc_valid), 32'h0);

        // R2 staging readback
        csr_write(OFS_DST, 32'hDEAD_BEEF);   csr_read(OFS_DST, r);     check("R2 dst", r, 32'hDEAD_BEEF);
        csr_write(OFS_SRC, 32'h1234_5670);   csr_read(OFS_SRC, r);     check("R2 src", r, 32'h1234_5670);
        csr_write(OFS_XLEN, 32'hFF12_3456);  csr_read(OFS_XLEN, r);    check("R2 xlen", r, 32'h0012_3456);
        csr_write(OFS_YLEN, 32'h0000_0007);  csr_read(OFS_YLEN, r);    check("R2 ylen", r, 32'h7);
        csr_write(OFS_DSTRIDE, 32'h0000_0400); csr_read(OFS_DSTRIDE, r); check("R2 dstride", r, 32'h400);
        csr_write(OFS_SSTRIDE, 32'hAB00_0800); csr_read(OFS_SSTRIDE, r); check("R2 sstride", r, 32'h800);
        csr_write(OFS_FLAGS, 32'h3);         csr_read(OFS_FLAGS, r);   check("R2 flags", r, 32'h1);
        #1 check("R2 desc ylen idle", 32'(desc_valid), 32'h0);

        // R3 submission ignored while disabled
        submit(32'h100, 32'h200, 32'h10, 0);
        csr_read(OFS_NEXTID, r); check("R3 disabled", r, 32'h0);

        // R5 pause holds valid low
        csr_write(OFS_CTRL, 32'h3); en_model = 1;
        submit(32'h1000, 32'h2000, 32'h3F, 0);
        #1 check("R5 paused", 32'(desc_valid), 32'h0);
        csr_write(OFS_CTRL, 32'h1);
        #1 check("R5 resumed", 32'(desc_valid), 32'h1);
        check("R2 desc ylen", 32'(desc_ylen), 32'h7);
        check("R2 desc stride", 32'(desc_dstride), 32'h400);

        // R4 fill and overflow
        submit(32'h1100, 32'h2100, 32'h4F, 0);
        submit(32'h1200, 32'h2200, 32'h5F, 0);
        submit(32'h1300, 32'h2300, 32'h6F, 0);
        csr_read(OFS_START, r);  check("R4 full flag", r, 32'h1);
        csr_read(OFS_STATUS, r); check("R10 status full", r, 32'h403);
        submit(32'h1400, 32'h2400, 32'h7F, 0);
        csr_read(OFS_NEXTID, r); check("R4 id held", r, 32'h4);
        for (int i = 0; i < 4; i++) pop_check("R3 R5 order", 0);
        csr_read(OFS_START, r);  check("R4 not full", r, 32'h0);
        csr_read(OFS_IPEND, r);  check("R7 sot", r, 32'h1);
        csr_read(OFS_ACTID, r);  check("R11 actid", r, 32'h3);
        csr_read(OFS_CURSRC, r); check("R11 cursrc", r, 32'h1300);
        csr_read(OFS_CURDST, r); check("R11 curdst", r, 32'h2300);

        // R8 mask and source
        csr_write(OFS_IMASK, 32'h0);
        #1 check("R8 irq on", 32'(irq), 32'h1);
        csr_read(OFS_ISRC, r); check("R8 source", r, 32'h1);
        csr_write(OFS_IMASK, 32'h1);
        #1 check("R8 irq masked", 32'(irq), 32'h0);
        csr_write(OFS_IPEND, 32'h1);
        csr_read(OFS_IPEND, r); check("R7 w1c", r, 32'h0);

        // R9 completion
        complete(2);
        csr_read(OFS_DONE, r);  check("R9 done set", r, done_model);
        csr_read(OFS_IPEND, r); check("R7 eot", r, 32'h2);
        #1 check("R8 irq eot", 32'(irq), 32'h1);

        // random phase
        for (int it = 0; it < 120; it++) begin
            int unsigned k;
            k = $urandom % 4;
            if (k < 2) begin
                if (m_id.size() < QDEPTH) begin
                    submit($urandom, $urandom, $urandom, 0);
                end else begin
                    submit(32'h5, 32'h6, 32'h7, 0);
                    csr_read(OFS_NEXTID, r); check("R4 rand full", r, 32'(next_model));
                end
            end else if (k == 2) begin
                if (m_id.size() > 0) pop_check("R5 rand", 0);
            end else begin
                complete(int'($urandom % 32));
                csr_read(OFS_DONE, r); check("R9 rand done", r, done_model);
            end
        end
        while (m_id.size() > 0) pop_check("R5 drain", 0);

        // R9 done bit cleared on reuse
        complete(next_model);
        csr_read(OFS_DONE, r); check("R9 before reuse", r, done_model);
        submit(32'h7700, 32'h8800, 32'h1, 0);
        csr_read(OFS_DONE, r); check("R9 cleared on reuse", r, done_model);
        pop_check("R5 reuse", 0);

        // R6 cyclic
        cyc_id = next_model;
        submit(32'hC000, 32'hD000, 32'h20, 1);
        for (int i = 0; i < 3; i++) begin
            pop_check("R6 cyclic", 1);
            check("R6 flag", 32'(desc_cyclic), 32'h1);
        end
        csr_read(OFS_ACTID, r); check("R11 cyclic actid", r, 32'(cyc_id));

        // R10 abort
        csr_write(OFS_CTRL, 32'h0); en_model = 0;
        m_id.delete(); m_src.delete(); m_dst.delete(); m_xlen.delete();
        csr_read(OFS_STATUS, r); check("R10 flushed", r, 32'h0);
        check("R10 valid low", 32'(desc_valid), 32'h0);
        csr_read(OFS_NEXTID, r); check("R10 id kept", r, 32'(next_model));
        csr_write(OFS_CTRL, 32'h1);
        #1 check("R10 stays empty", 32'(desc_valid), 32'h0);

        // R7 set beats clear in same cycle
        csr_write(OFS_IPEND, 32'h3);
        @(negedge clk);
        csr_addr = OFS_IPEND; csr_wdata = 32'h2; csr_wen = 1'b1;
        cpl_valid = 1'b1; cpl_id = 5'd9;
        @(negedge clk);
        csr_wen = 1'b0; cpl_valid = 1'b0;
        done_model[9] = 1'b1;
        csr_read(OFS_IPEND, r); check("R7 set wins", r, 32'h2);
        csr_read(OFS_DONE, r);  check("R9 final", r, done_model);

        summary();
        $finish;
    end

endmodule